// File: doc/BRIEF.md
# Separable Two-Stage Matching Allocator

This block turns a matrix of requests, in which each of `NUM_REQ` requesters may ask for any of `NUM_RES` resources, into a grant matrix. In the grant matrix each requester holds at most one resource and each resource goes to at most one requester. Two banks of round-robin arbiters build the matching. One bank has an arbiter per requester row and the other has an arbiter per resource column. The arbiters within a bank run independently of each other. The `OUTPUT_FIRST` parameter sets which bank acts first. With the value 0, each requester first chooses one resource, and each resource then chooses among the requesters that picked it. With the value 1, the order is reversed.

The matching is computed in one cycle and then registered. A switch or a channel allocator can drive the request matrix on every cycle and read the grants one cycle later. An arbiter moves its priority pointer only when `updEn` is high and its own winner survives the other stage. Because the first stage decides without seeing the second, the matching is legal but not always as large as it could be.

Top module: `separable_alloc`

## Requirements
- R1: In `grantOut`, at most one bit is set among the bits of any one requester row (bits `i*NUM_RES` to `i*NUM_RES+NUM_RES-1`).
- R2: In `grantOut`, at most one bit is set among the bits of any one resource column (bits `j`, `NUM_RES+j`, `2*NUM_RES+j`, and so on).
- R3: Every set bit of `grantOut` is also set in the `reqIn` value sampled at the previous rising edge. Bit `i*NUM_RES+j` means requester `i` and resource `j`.
- R4: `grantOut` is a register. After each rising edge it holds the matching of the `reqIn` value sampled at that edge. While `rstN` is low it is all zeros.
- R5: An all-zero `reqIn` gives an all-zero `grantOut` after the next edge and leaves every priority pointer where it was.
- R6: Each arbiter is round-robin. After reset every pointer is at index 0. An arbiter picks the first requesting index at or above its pointer, wrapping cyclically. When its pointer advances, the pointer moves to the winner index plus one, modulo the arbiter width.
- R7: A pointer advances at an edge only if `updEn` is high at that edge and the arbiter's winner appears in the final grant. While `updEn` is low, an unchanged `reqIn` gives an unchanged `grantOut`.
- R8: With `OUTPUT_FIRST=0` the row arbiters act first. With `OUTPUT_FIRST=1` the column arbiters act first. Example, just after reset, for the requests r0c0, r1c0 and r1c1: the first order grants only r0c0, and the second order grants r0c0 and r1c1.
- R9: The matching need not be maximal. In the R8 example with `OUTPUT_FIRST=0`, only one grant is given although two could be given.
- R10: If `reqIn` is held constant with `updEn` high, every requested pair is granted within `2*NUM_REQ*NUM_RES` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | NUM_REQ*NUM_RES | Request matrix, bit i*NUM_RES+j = requester i wants resource j |
| updEn | input | 1 | Allows the priority pointers to advance at this edge |
| grantOut | output | NUM_REQ*NUM_RES | Registered grant matrix, same bit layout as reqIn |

## Verification
In a single cycle, the first-stage choice of a row and the second-stage decision of a column both act on the same request bit. Both pointer updates then take effect at the same edge. Random request matrices provoke this on every cycle, and `updEn` toggles at random so that moving and frozen pointers are mixed. The result is judged against a bench model of both stage orders that keeps its own pointers. Each grant is also checked independently for the row, column and subset rules.

// File: rtl/sa_pkg.sv
package sa_pkg;

  typedef struct packed {
    logic load;     // capture the new matching into the grant register
    logic advance;  // pointers may move this edge
  } saStrobe_t;

  function automatic int idxWidth(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] reqVec,
  input  logic             advance,
  output logic [WIDTH-1:0] gntVec
);
  localparam int IDX_W = sa_pkg::idxWidth(WIDTH);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIDTH - 1);

  logic [IDX_W-1:0] ptrQ;
  logic [IDX_W-1:0] winIdx;
  logic             found;

  // scan upward from the pointer, wrapping once around
  always_comb begin
    gntVec = '0;
    found  = 1'b0;
    winIdx = '0;
    for (int k = 0; k < WIDTH; k++) begin
      int idx;
      idx = int'(ptrQ) + k;
      if (idx >= WIDTH) idx = idx - WIDTH;
      if (!found && reqVec[idx]) begin
        found       = 1'b1;
        gntVec[idx] = 1'b1;
        winIdx      = IDX_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (advance && found) begin
      ptrQ <= (winIdx == LAST_IDX) ? '0 : winIdx + 1'b1;
    end
  end

  AST_ARB_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gntVec) && ((gntVec & ~reqVec) == '0)); // R6

  AST_ARB_WORK: assert property (@(posedge clk) disable iff (!rstN)
    (|reqVec) |-> (|gntVec)); // R6

endmodule

// File: rtl/sa_control.sv
module sa_control (
  input  logic              updEn,
  input  logic              anyReq,
  output sa_pkg::saStrobe_t strobe
);
  always_comb begin
    strobe.load    = 1'b1;
    strobe.advance = updEn && anyReq;
  end
endmodule

// File: rtl/sa_datapath.sv
module sa_datapath #(
  parameter int NUM_REQ      = 4,
  parameter int NUM_RES      = 4,
  parameter bit OUTPUT_FIRST = 1'b0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_REQ*NUM_RES-1:0] reqIn,
  input  sa_pkg::saStrobe_t          strobe,
  output logic                       anyReq,
  output logic [NUM_REQ*NUM_RES-1:0] grantOut
);
  logic [NUM_REQ-1:0][NUM_RES-1:0] reqM, rowIn, rowGnt, grantNext, grantQ;
  logic [NUM_RES-1:0][NUM_REQ-1:0] colIn, colGnt, grantNextT, grantQT;
  logic [NUM_REQ-1:0] rowAdv;
  logic [NUM_RES-1:0] colAdv;

  assign reqM     = reqIn;
  assign anyReq   = |reqIn;
  assign grantOut = grantQ;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_row
    for (genvar j = 0; j < NUM_RES; j++) begin : g_cell
      assign grantNextT[j][i] = grantNext[i][j];
      assign grantQT[j][i]    = grantQ[i][j];
      if (!OUTPUT_FIRST) begin : g_in_first
        assign rowIn[i][j]     = reqM[i][j];
        assign colIn[j][i]     = rowGnt[i][j];
        assign grantNext[i][j] = colGnt[j][i];
      end else begin : g_out_first
        assign colIn[j][i]     = reqM[i][j];
        assign rowIn[i][j]     = colGnt[j][i];
        assign grantNext[i][j] = rowGnt[i][j];
      end
    end

    assign rowAdv[i] = strobe.advance && (|grantNext[i]);

    rr_arbiter #(.WIDTH(NUM_RES)) u_rowArb (
      .clk     (clk),
      .rstN    (rstN),
      .reqVec  (rowIn[i]),
      .advance (rowAdv[i]),
      .gntVec  (rowGnt[i])
    );

    AST_ROW_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(grantQ[i])); // R1
  end

  for (genvar j = 0; j < NUM_RES; j++) begin : g_col
    assign colAdv[j] = strobe.advance && (|grantNextT[j]);

    rr_arbiter #(.WIDTH(NUM_REQ)) u_colArb (
      .clk     (clk),
      .rstN    (rstN),
      .reqVec  (colIn[j]),
      .advance (colAdv[j]),
      .gntVec  (colGnt[j])
    );

    AST_COL_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(grantQT[j])); // R2
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantQ <= '0;
    end else if (strobe.load) begin
      grantQ <= grantNext;
    end
  end

  AST_GRANT_SUBSET: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((grantOut & ~$past(reqIn)) == '0)); // R3

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (reqIn == '0) |=> (grantOut == '0)); // R5

  AST_HOLD_NO_ADV: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.advance) |=> (!$stable(reqIn) || $stable(grantNext))); // R7

endmodule

// File: rtl/separable_alloc.sv
module separable_alloc #(
  parameter int NUM_REQ      = 4,
  parameter int NUM_RES      = 4,
  parameter bit OUTPUT_FIRST = 1'b0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_REQ*NUM_RES-1:0] reqIn,
  input  logic                       updEn,
  output logic [NUM_REQ*NUM_RES-1:0] grantOut
);
  sa_pkg::saStrobe_t strobe;
  logic anyReq;

  sa_control u_ctrl (
    .updEn  (updEn),
    .anyReq (anyReq),
    .strobe (strobe)
  );

  sa_datapath #(
    .NUM_REQ      (NUM_REQ),
    .NUM_RES      (NUM_RES),
    .OUTPUT_FIRST (OUTPUT_FIRST)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .reqIn    (reqIn),
    .strobe   (strobe),
    .anyReq   (anyReq),
    .grantOut (grantOut)
  );
endmodule

// File: tb/sim_separable_alloc.sv
module sim_separable_alloc;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int M  = 4;
  localparam int NM = N * M;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic updEn = 1'b0;
  logic [NM-1:0] reqIn = '0;
  logic [NM-1:0] g0, g1;

  always #(CLK_PERIOD/2) clk = ~clk;

  separable_alloc #(.NUM_REQ(N), .NUM_RES(M), .OUTPUT_FIRST(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .updEn(updEn), .grantOut(g0));
  separable_alloc #(.NUM_REQ(N), .NUM_RES(M), .OUTPUT_FIRST(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .updEn(updEn), .grantOut(g1));

  int checks = 0;
  int errors = 0;
  int rowPtr[2][N];
  int colPtr[2][M];
  logic [NM-1:0] exp0, exp1;

  function automatic int rrPick(input logic [31:0] v, input int w, input int p);
    for (int k = 0; k < w; k++) begin
      int idx;
      idx = (p + k) % w;
      if (v[idx]) return idx;
    end
    return -1;
  endfunction

  task automatic model(input int md, input logic [NM-1:0] r, input logic u,
                       output logic [NM-1:0] g);
    logic [NM-1:0] pick;
    logic [31:0] v;
    int w;
    g = '0; pick = '0;
    if (md == 0) begin
      for (int i = 0; i < N; i++) begin
        v = '0;
        for (int j = 0; j < M; j++) v[j] = r[i*M+j];
        w = rrPick(v, M, rowPtr[md][i]);
        if (w >= 0) pick[i*M+w] = 1'b1;
      end
      for (int j = 0; j < M; j++) begin
        v = '0;
        for (int i = 0; i < N; i++) v[i] = pick[i*M+j];
        w = rrPick(v, N, colPtr[md][j]);
        if (w >= 0) g[w*M+j] = 1'b1;
      end
    end else begin
      for (int j = 0; j < M; j++) begin
        v = '0;
        for (int i = 0; i < N; i++) v[i] = r[i*M+j];
        w = rrPick(v, N, colPtr[md][j]);
        if (w >= 0) pick[w*M+j] = 1'b1;
      end
      for (int i = 0; i < N; i++) begin
        v = '0;
        for (int j = 0; j < M; j++) v[j] = pick[i*M+j];
        w = rrPick(v, M, rowPtr[md][i]);
        if (w >= 0) g[i*M+w] = 1'b1;
      end
    end
    if (u) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < M; j++)
          if (g[i*M+j]) begin
            rowPtr[md][i] = (j + 1) % M;
            colPtr[md][j] = (i + 1) % N;
          end
    end
  endtask

  // drive at a falling edge, let one rising edge register, sample at next falling edge
  task automatic step(input logic [NM-1:0] r, input logic u);
    reqIn = r;
    updEn = u;
    model(0, r, u, exp0);
    model(1, r, u, exp1);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [NM-1:0] act, input logic [NM-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit rowsOk(input logic [NM-1:0] g);
    for (int i = 0; i < N; i++) begin
      int c;
      c = 0;
      for (int j = 0; j < M; j++) c += int'(g[i*M+j]);
      if (c > 1) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic bit colsOk(input logic [NM-1:0] g);
    for (int j = 0; j < M; j++) begin
      int c;
      c = 0;
      for (int i = 0; i < N; i++) c += int'(g[i*M+j]);
      if (c > 1) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic chkBit(input string tag, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  localparam logic [NM-1:0] PAT_A = 16'h0031; // r0c0, r1c0, r1c1

  initial begin
    logic [NM-1:0] r;
    logic [NM-1:0] first;
    int wait0, wait1;
    for (int i = 0; i < N; i++) begin rowPtr[0][i] = 0; rowPtr[1][i] = 0; end
    for (int j = 0; j < M; j++) begin colPtr[0][j] = 0; colPtr[1][j] = 0; end
    void'($urandom(32'd20240611));

    // reset state, with requests present during reset
    reqIn = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R4 reset u0", g0, '0);
    chk("R4 reset u1", g1, '0);
    rstN = 1'b1;

    // stage order and non-maximal matching
    step(PAT_A, 1'b0);
    chk("R8 input-first", g0, 16'h0001);
    chk("R8 output-first", g1, 16'h0021);
    chkBit("R9 one grant only", ($countones(g0) == 1), 1'b1);

    // idle: no grant, no pointer motion even with updEn
    step('0, 1'b1);
    chk("R5 idle u0", g0, '0);
    chk("R5 idle u1", g1, '0);
    step(PAT_A, 1'b0);
    chk("R5 pointers kept u0", g0, 16'h0001);
    chk("R5 pointers kept u1", g1, 16'h0021);

    // frozen pointers with full requests
    step('1, 1'b0);
    first = g0;
    chk("R6 full at reset ptr u0", g0, 16'h0001);
    chk("R6 full at reset ptr u1", g1, 16'h0001);
    step('1, 1'b0);
    chk("R7 frozen repeat u0", g0, first);
    step('1, 1'b0);
    chk("R7 frozen repeat u1", g1, 16'h0001);
    step('1, 1'b1);
    chk("R7 advance edge u0", g0, 16'h0001);
    step('1, 1'b0);
    chk("R6 pointer moved past winner u0", g0, 16'h0012);
    chk("R6 pointer moved past winner u1", g1, 16'h0012);

    // random traffic, pointers moving or frozen at random
    for (int n = 0; n < 600; n++) begin
      int dens;
      logic u;
      dens = int'($urandom % 4);
      r = '0;
      for (int b = 0; b < NM; b++) r[b] = (int'($urandom % 4) <= dens);
      if (n % 37 == 0) r = '0;
      u = ($urandom % 4) != 0;
      step(r, u);
      chk("R4 matching u0", g0, exp0);
      chk("R4 matching u1", g1, exp1);
      chkBit("R1 row rule u0", rowsOk(g0), 1'b1);
      chkBit("R1 row rule u1", rowsOk(g1), 1'b1);
      chkBit("R2 column rule u0", colsOk(g0), 1'b1);
      chkBit("R2 column rule u1", colsOk(g1), 1'b1);
      chkBit("R3 subset u0", ((g0 & ~r) == '0), 1'b1);
      chkBit("R3 subset u1", ((g1 & ~r) == '0), 1'b1);
    end

    // constant request: target r3c2 (bit 14) must be served
    for (int pass = 0; pass < 2; pass++) begin
      r = (pass == 0) ? '1 : 16'h4C63;
      wait0 = -1; wait1 = -1;
      for (int c = 0; c < 2*NM; c++) begin
        step(r, 1'b1);
        if (wait0 < 0 && g0[14]) wait0 = c;
        if (wait1 < 0 && g1[14]) wait1 = c;
      end
      chkBit("R10 held request served u0", (wait0 >= 0), 1'b1);
      chkBit("R10 held request served u1", (wait1 >= 0), 1'b1);
    end

    finishRun();
  end
endmodule